// File: doc/BRIEF.md
# Immediate-Operand Integer Instruction Executor

This block runs a narrow slice of a 32-bit integer instruction set in which every instruction carries a 32-bit immediate. It pulls instruction bytes one at a time from a fetch port. It decodes an opcode, an optional addressing byte and four immediate bytes. It then updates one of eight 32-bit registers, a word in data memory, or the sign, zero and overflow flags.

The operand is either a register named by the addressing byte or the memory word whose byte address sits in a register. Memory is reached through a single byte-wide port with a request/ready handshake, so a word takes four transfers with the least significant byte at the lowest address. The block pulses `done` when an instruction retires. On anything it does not support it pulses `err` and parks in a halted state until reset. A read-only select port shows any register, so the surrounding logic and the bench can observe architectural state.

Top module: `imm_exec_core`

## Requirements
- R1: Opcode 0x81 takes its operation from bits 5:3 of the addressing byte: 0 add, 1 or, 4 and, 5 subtract, 6 xor, 7 compare. Values 2 and 3 raise `err` and halt, and leave every register unchanged.
- R2: The four immediate bytes arrive least significant first, so the stream 0a 0b 0c 0d yields 0x0d0c0b0a.
- R3: In the addressing byte, bits 7:6 = 3 select register bits 2:0 as the operand. Bits 7:6 = 0 select the memory word at the address held in that register. Modes 1 and 2, and mode 0 with bits 2:0 equal to 4 or 5, raise `err`.
- R4: Opcodes 0x0d (or), 0x25 (and), 0x2d (subtract), 0x35 (xor) and 0x3d (compare) have no addressing byte and act on register 0.
- R5: Compare forms the operand minus the immediate and writes no register or memory. It sets sign to bit 31 of the difference and zero when the difference is 0. It sets overflow when the 32-bit difference differs from the exact signed difference.
- R6: Add, or, and, subtract, xor, move and push leave all three flags unchanged.
- R7: Opcodes 0xb8 to 0xbf load the immediate into the register whose index is the opcode's low three bits.
- R8: Opcode 0xc7 copies the immediate into the register or memory word chosen by the addressing byte, and performs no memory read.
- R9: Opcode 0x68 lowers register 4 by 4 and then stores the immediate as four bytes at the new register 4 value and the three addresses above it.
- R10: A read-modify-write on memory reads bytes at base, base+1, base+2 and base+3, then writes the same four addresses in the same order. `fetch_ready` is low while memory is busy.
- R11: `done` is a one-cycle pulse, raised once for each retired instruction, in the cycle in which its results are visible.
- R12: An unsupported opcode raises a one-cycle `err` and sets `halted`. While `halted` is high, `fetch_ready` and `mem_req` stay low until reset.
- R13: A synchronous reset clears all registers, flags and `halted`, and returns the decoder to opcode fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Instruction byte offered |
| fetch_byte | input | 8 | Instruction byte |
| fetch_ready | output | 1 | Byte taken when high with fetch_valid |
| mem_req | output | 1 | Memory byte transfer requested |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | ADDR_W | Byte address of the transfer |
| mem_wdata | output | 8 | Write data byte |
| mem_rdata | input | 8 | Read data byte, valid with mem_ready |
| mem_ready | input | 1 | Transfer completes this cycle |
| dbg_sel | input | 3 | Register index to observe |
| dbg_data | output | DATA_W | Contents of the selected register |
| flag_sign | output | 1 | Sign flag |
| flag_zero | output | 1 | Zero flag |
| flag_ovf | output | 1 | Overflow flag |
| done | output | 1 | Instruction retired pulse |
| err | output | 1 | Unsupported encoding pulse |
| halted | output | 1 | Sticky halt |

## Verification
The bench targets signed overflow in both directions of a compare, and a compare result that is negative but not overflowed. A design that took overflow from the carry or from the sign alone would give the wrong flags on one of these. Flags set by an earlier compare are carried through later arithmetic, because a design that updated flags on every operation would silently clear them. The memory cases record the address order of every byte transfer, which exposes a write issued before the read completes and a byte-lane swap. Illegal sub-operations, unsupported addressing modes and unknown opcodes are each fed in; a design that accepted them would corrupt a register or keep fetching.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;

   typedef enum logic [2:0] {
      OP_ADD, OP_OR, OP_AND, OP_SUB, OP_XOR, OP_CMP, OP_MOV
   } alu_op_e;

   typedef enum logic [1:0] {
      K_ALU, K_MOV, K_PUSH
   } kind_e;

   typedef enum logic [2:0] {
      ST_OPC, ST_MODRM, ST_IMM, ST_DISP, ST_RD, ST_EXEC, ST_WR, ST_HALT
   } state_e;

   typedef struct packed {
      logic       legal;
      logic       has_modrm;
      logic       grp;
      kind_e      kind;
      alu_op_e    op;
      logic [2:0] idx;
   } dec_t;

   localparam logic [7:0] OPC_GRP   = 8'h81;
   localparam logic [7:0] OPC_OR0   = 8'h0d;
   localparam logic [7:0] OPC_AND0  = 8'h25;
   localparam logic [7:0] OPC_SUB0  = 8'h2d;
   localparam logic [7:0] OPC_XOR0  = 8'h35;
   localparam logic [7:0] OPC_CMP0  = 8'h3d;
   localparam logic [7:0] OPC_MOVRM = 8'hc7;
   localparam logic [7:0] OPC_PUSH  = 8'h68;
   localparam logic [4:0] OPC_MOVR_HI = 5'b10111;

   function automatic logic sub_ok(input logic [2:0] s);
      return !(s == 3'd2 || s == 3'd3);
   endfunction

   function automatic alu_op_e sub_map(input logic [2:0] s);
      case (s)
         3'd0:    return OP_ADD;
         3'd1:    return OP_OR;
         3'd4:    return OP_AND;
         3'd5:    return OP_SUB;
         3'd6:    return OP_XOR;
         default: return OP_CMP;
      endcase
   endfunction

endpackage

// File: rtl/imm_exec_decode.sv
module imm_exec_decode
   import imm_exec_pkg::*;
#(
   parameter int SP_IDX = 4
) (
   input  logic [7:0] opc,
   output dec_t       dec
);

   always_comb begin
      dec           = '0;
      dec.kind      = K_ALU;
      dec.op        = OP_ADD;
      case (opc)
         OPC_GRP: begin
            dec.legal     = 1'b1;
            dec.has_modrm = 1'b1;
            dec.grp       = 1'b1;
         end
         OPC_OR0:  begin dec.legal = 1'b1; dec.op = OP_OR;  end
         OPC_AND0: begin dec.legal = 1'b1; dec.op = OP_AND; end
         OPC_SUB0: begin dec.legal = 1'b1; dec.op = OP_SUB; end
         OPC_XOR0: begin dec.legal = 1'b1; dec.op = OP_XOR; end
         OPC_CMP0: begin dec.legal = 1'b1; dec.op = OP_CMP; end
         OPC_MOVRM: begin
            dec.legal     = 1'b1;
            dec.has_modrm = 1'b1;
            dec.kind      = K_MOV;
            dec.op        = OP_MOV;
         end
         OPC_PUSH: begin
            dec.legal = 1'b1;
            dec.kind  = K_PUSH;
            dec.op    = OP_MOV;
            dec.idx   = 3'(SP_IDX);
         end
         default: begin
            if (opc[7:3] == OPC_MOVR_HI) begin
               dec.legal = 1'b1;
               dec.kind  = K_MOV;
               dec.op    = OP_MOV;
               dec.idx   = opc[2:0];
            end
         end
      endcase
   end

endmodule

// File: rtl/imm_exec_regfile.sv
module imm_exec_regfile #(
   parameter int NREG   = 8,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ra,
   output logic [DATA_W-1:0] rd,
   input  logic [IDX_W-1:0]  rb,
   output logic [DATA_W-1:0] rbd
);

   logic [DATA_W-1:0] q [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (rst)
            q[g] <= '0;
         else if (we && waddr == IDX_W'(g))
            q[g] <= wdata;
      end
   end

   assign rd  = q[ra];
   assign rbd = q[rb];

endmodule

// File: rtl/imm_exec_alu.sv
module imm_exec_alu
   import imm_exec_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit WIDE_OVF = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  alu_op_e           op,
   output logic [DATA_W-1:0] res,
   output logic              sf,
   output logic              zf,
   output logic              of
);

   logic [DATA_W-1:0] diff;

   assign diff = a - b;
   assign sf   = diff[DATA_W-1];
   assign zf   = (diff == '0);

   if (WIDE_OVF) begin : g_ovf_wide
      logic [DATA_W:0] wide;
      assign wide = {a[DATA_W-1], a} - {b[DATA_W-1], b};
      assign of   = wide[DATA_W] ^ wide[DATA_W-1];
   end else begin : g_ovf_sign
      assign of = (a[DATA_W-1] ^ b[DATA_W-1]) & (diff[DATA_W-1] ^ a[DATA_W-1]);
   end

   always_comb begin
      case (op)
         OP_ADD:  res = a + b;
         OP_OR:   res = a | b;
         OP_AND:  res = a & b;
         OP_SUB:  res = diff;
         OP_XOR:  res = a ^ b;
         OP_MOV:  res = b;
         default: res = a;
      endcase
   end

endmodule

// File: rtl/imm_exec_core.sv
module imm_exec_core
   import imm_exec_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NREG     = 8,
   parameter int ADDR_W   = 32,
   parameter int SP_IDX   = 4,
   parameter bit WIDE_OVF = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     fetch_valid,
   input  logic [7:0]               fetch_byte,
   output logic                     fetch_ready,
   output logic                     mem_req,
   output logic                     mem_we,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [7:0]               mem_wdata,
   input  logic [7:0]               mem_rdata,
   input  logic                     mem_ready,
   input  logic [$clog2(NREG)-1:0]  dbg_sel,
   output logic [DATA_W-1:0]        dbg_data,
   output logic                     flag_sign,
   output logic                     flag_zero,
   output logic                     flag_ovf,
   output logic                     done,
   output logic                     err,
   output logic                     halted
);

   localparam int BYTES = DATA_W / 8;
   localparam int CNT_W = $clog2(BYTES);
   localparam int IDX_W = $clog2(NREG);

   if (DATA_W != 32) begin : g_bad_width
      $error("imm_exec_core: DATA_W must be 32");
   end
   if (NREG != 8) begin : g_bad_nreg
      $error("imm_exec_core: NREG must be 8 to match the 3-bit register fields");
   end
   if (ADDR_W < 8 || ADDR_W > DATA_W) begin : g_bad_addr
      $error("imm_exec_core: ADDR_W must lie between 8 and DATA_W");
   end
   if (SP_IDX < 0 || SP_IDX >= NREG) begin : g_bad_sp
      $error("imm_exec_core: SP_IDX out of range");
   end

   state_e             st;
   logic [CNT_W-1:0]   cnt;
   logic [DATA_W-1:0]  imm;
   logic [DATA_W-1:0]  opnd;
   logic [DATA_W-1:0]  wbuf;
   logic [DATA_W-1:0]  base;
   kind_e              kind_q;
   alu_op_e            op_q;
   logic               grp_q;
   logic [IDX_W-1:0]   idx_q;
   logic               mem_q;
   logic               done_q;
   logic               err_q;
   logic               sf_q, zf_q, of_q;

   dec_t               dec;
   logic               take;
   logic               cnt_last;
   logic [1:0]         m_mode;
   logic [2:0]         m_reg;
   logic [2:0]         m_rm;
   logic               m_bad;

   logic [DATA_W-1:0]  rf_rd;
   logic               rf_we;
   logic [DATA_W-1:0]  rf_wdata;
   logic [DATA_W-1:0]  sp_next;

   logic [DATA_W-1:0]  alu_res;
   logic               alu_sf, alu_zf, alu_of;

   imm_exec_decode #(.SP_IDX(SP_IDX)) u_dec (
      .opc (fetch_byte),
      .dec (dec)
   );

   imm_exec_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
      .clk   (clk),
      .rst   (rst),
      .we    (rf_we),
      .waddr (idx_q),
      .wdata (rf_wdata),
      .ra    (idx_q),
      .rd    (rf_rd),
      .rb    (dbg_sel),
      .rbd   (dbg_data)
   );

   imm_exec_alu #(.DATA_W(DATA_W), .WIDE_OVF(WIDE_OVF)) u_alu (
      .a   (opnd),
      .b   (imm),
      .op  (op_q),
      .res (alu_res),
      .sf  (alu_sf),
      .zf  (alu_zf),
      .of  (alu_of)
   );

   assign fetch_ready = (st == ST_OPC) || (st == ST_MODRM) || (st == ST_IMM);
   assign take        = fetch_valid && fetch_ready;
   assign cnt_last    = (cnt == CNT_W'(BYTES - 1));

   assign m_mode = fetch_byte[7:6];
   assign m_reg  = fetch_byte[5:3];
   assign m_rm   = fetch_byte[2:0];
   assign m_bad  = (m_mode == 2'd1) || (m_mode == 2'd2) ||
                   (m_mode == 2'd0 && (m_rm == 3'd4 || m_rm == 3'd5)) ||
                   (grp_q && !sub_ok(m_reg));

   assign sp_next  = rf_rd - DATA_W'(BYTES);
   assign rf_we    = (st == ST_DISP && kind_q == K_PUSH) ||
                     (st == ST_EXEC && !mem_q && op_q != OP_CMP);
   assign rf_wdata = (st == ST_DISP) ? sp_next : alu_res;

   assign mem_req   = (st == ST_RD) || (st == ST_WR);
   assign mem_we    = (st == ST_WR);
   assign mem_addr  = base[ADDR_W-1:0] + ADDR_W'(cnt);
   assign mem_wdata = wbuf[7:0];

   assign done      = done_q;
   assign err       = err_q;
   assign halted    = (st == ST_HALT);
   assign flag_sign = sf_q;
   assign flag_zero = zf_q;
   assign flag_ovf  = of_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= ST_OPC;
         cnt    <= '0;
         imm    <= '0;
         opnd   <= '0;
         wbuf   <= '0;
         base   <= '0;
         kind_q <= K_ALU;
         op_q   <= OP_ADD;
         grp_q  <= 1'b0;
         idx_q  <= '0;
         mem_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         sf_q   <= 1'b0;
         zf_q   <= 1'b0;
         of_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (st)
            ST_OPC: begin
               if (take) begin
                  if (!dec.legal) begin
                     err_q <= 1'b1;
                     st    <= ST_HALT;
                  end else begin
                     kind_q <= dec.kind;
                     op_q   <= dec.op;
                     grp_q  <= dec.grp;
                     idx_q  <= IDX_W'(dec.idx);
                     mem_q  <= 1'b0;
                     cnt    <= '0;
                     st     <= dec.has_modrm ? ST_MODRM : ST_IMM;
                  end
               end
            end
            ST_MODRM: begin
               if (take) begin
                  if (m_bad) begin
                     err_q <= 1'b1;
                     st    <= ST_HALT;
                  end else begin
                     idx_q <= IDX_W'(m_rm);
                     mem_q <= (m_mode == 2'd0);
                     if (grp_q)
                        op_q <= sub_map(m_reg);
                     st <= ST_IMM;
                  end
               end
            end
            ST_IMM: begin
               if (take) begin
                  imm <= {fetch_byte, imm[DATA_W-1:8]};
                  cnt <= cnt + 1'b1;
                  if (cnt_last)
                     st <= ST_DISP;
               end
            end
            ST_DISP: begin
               cnt <= '0;
               if (kind_q == K_PUSH) begin
                  base <= sp_next;
                  wbuf <= imm;
                  st   <= ST_WR;
               end else if (mem_q) begin
                  base <= rf_rd;
                  wbuf <= imm;
                  st   <= (kind_q == K_MOV) ? ST_WR : ST_RD;
               end else begin
                  opnd <= rf_rd;
                  st   <= ST_EXEC;
               end
            end
            ST_RD: begin
               if (mem_ready) begin
                  opnd <= {mem_rdata, opnd[DATA_W-1:8]};
                  cnt  <= cnt + 1'b1;
                  if (cnt_last)
                     st <= ST_EXEC;
               end
            end
            ST_EXEC: begin
               cnt <= '0;
               if (op_q == OP_CMP) begin
                  sf_q   <= alu_sf;
                  zf_q   <= alu_zf;
                  of_q   <= alu_of;
                  done_q <= 1'b1;
                  st     <= ST_OPC;
               end else if (mem_q) begin
                  wbuf <= alu_res;
                  st   <= ST_WR;
               end else begin
                  done_q <= 1'b1;
                  st     <= ST_OPC;
               end
            end
            ST_WR: begin
               if (mem_ready) begin
                  wbuf <= wbuf >> 8;
                  cnt  <= cnt + 1'b1;
                  if (cnt_last) begin
                     done_q <= 1'b1;
                     st     <= ST_OPC;
                  end
               end
            end
            default: st <= ST_HALT;
         endcase
      end
   end

endmodule

// File: rtl/imm_exec_chk.sv
module imm_exec_chk (
   input logic clk,
   input logic rst,
   input logic fetch_ready,
   input logic mem_req,
   input logic done,
   input logic err,
   input logic halted,
   input logic flag_sign,
   input logic flag_zero,
   input logic flag_ovf
);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);                                              // R11

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);                                           // R12

   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
      halted |-> (!fetch_ready && !mem_req));                       // R12

   AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
      err |-> halted);                                              // R12

   AST_FLAGS_ON_RETIRE: assert property (@(posedge clk) disable iff (rst)
      !$stable({flag_sign, flag_zero, flag_ovf}) |-> done);         // R5

   AST_MEM_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> !fetch_ready);                                    // R10

endmodule

bind imm_exec_core imm_exec_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .fetch_ready (fetch_ready),
   .mem_req     (mem_req),
   .done        (done),
   .err         (err),
   .halted      (halted),
   .flag_sign   (flag_sign),
   .flag_zero   (flag_zero),
   .flag_ovf    (flag_ovf)
);

// File: tb/imm_exec_core_tb_top.sv
`timescale 1ns/1ps
module imm_exec_core_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        fetch_valid;
   logic [7:0]  fetch_byte;
   logic        fetch_ready;
   logic        mem_req, mem_we, mem_ready;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic [2:0]  dbg_sel;
   logic [31:0] dbg_data;
   logic        flag_sign, flag_zero, flag_ovf;
   logic        done, err, halted;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   imm_exec_core dut_i (
      .clk(clk), .rst(rst),
      .fetch_valid(fetch_valid), .fetch_byte(fetch_byte), .fetch_ready(fetch_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .dbg_sel(dbg_sel), .dbg_data(dbg_data),
      .flag_sign(flag_sign), .flag_zero(flag_zero), .flag_ovf(flag_ovf),
      .done(done), .err(err), .halted(halted)
   );

   // memory model with alternating wait states and a transfer log
   logic [7:0] mem [256];
   logic [8:0] mlog [16];
   int         log_n = 0;
   int         done_n = 0;
   logic       stall = 1'b0;

   always @(posedge clk) stall <= ~stall;
   assign mem_ready = mem_req & stall;
   assign mem_rdata = mem[mem_addr[7:0]];

   always @(posedge clk) begin
      if (mem_req && mem_ready) begin
         if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
         if (log_n < 16) mlog[log_n] <= {mem_we, mem_addr[7:0]};
         log_n <= log_n + 1;
      end
      if (done) done_n <= done_n + 1;
   end

   typedef struct packed {
      logic [31:0] eax0;
      logic [31:0] ebx0;
      logic [31:0] mem0;
      logic [47:0] code;
      logic [2:0]  n;
      logic [1:0]  chk;
      logic [31:0] expv;
      logic [2:0]  expf;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VEC [NV] = '{
      '{32'h0d0c0b07, 32'h60, 32'h0,        48'h3d0a0b0c0d00, 3'd5, 2'd0, 32'h0d0c0b07, 3'b100},
      '{32'h0,        32'h1,  32'h0,        48'h81c30a0b0c0d, 3'd6, 2'd1, 32'h0d0c0b0b, 3'b100},
      '{32'h0,        32'h60, 32'h1,        48'h81030a0b0c0d, 3'd6, 2'd2, 32'h0d0c0b0b, 3'b100},
      '{32'h0d0c0baa, 32'h60, 32'h0,        48'h2d0a0b0c0d00, 3'd5, 2'd0, 32'h000000a0, 3'b100},
      '{32'h0,        32'h60, 32'h0a,       48'h812b01000000, 3'd6, 2'd2, 32'h00000009, 3'b100},
      '{32'h0,        32'h0a, 32'h0,        48'h81eb01000000, 3'd6, 2'd1, 32'h00000009, 3'b100},
      '{32'hff,       32'h60, 32'h0,        48'h250a0b0c0d00, 3'd5, 2'd0, 32'h0000000a, 3'b100},
      '{32'h0,        32'h60, 32'hff,       48'h81230a0b0c0d, 3'd6, 2'd2, 32'h0000000a, 3'b100},
      '{32'hd0c0b0a0, 32'h60, 32'h0,        48'h0d0a0b0c0d00, 3'd5, 2'd0, 32'hddccbbaa, 3'b100},
      '{32'h0,        32'hd0c0b0a0, 32'h0,  48'h81cb0a0b0c0d, 3'd6, 2'd1, 32'hddccbbaa, 3'b100},
      '{32'hddccb0a0, 32'h60, 32'h0,        48'h350a0b0c0d00, 3'd5, 2'd0, 32'hd0c0bbaa, 3'b100},
      '{32'h0,        32'h60, 32'hd0c0b0a0, 48'h81330a0b0c0d, 3'd6, 2'd2, 32'hddccbbaa, 3'b100},
      '{32'h0d0c0b0a, 32'h60, 32'h0,        48'h3d070b0c0d00, 3'd5, 2'd0, 32'h0d0c0b0a, 3'b000},
      '{32'h0,        32'h0d0c0b0a, 32'h0,  48'h81fb0a0b0c0d, 3'd6, 2'd1, 32'h0d0c0b0a, 3'b010},
      '{32'h0,        32'h60, 32'h0d0c0b07, 48'h813b0a0b0c0d, 3'd6, 2'd2, 32'h0d0c0b07, 3'b100},
      '{32'h80000000, 32'h60, 32'h0,        48'h3d0100000000, 3'd5, 2'd0, 32'h80000000, 3'b001},
      '{32'h7fffffff, 32'h60, 32'h0,        48'h3dffffffff00, 3'd5, 2'd0, 32'h7fffffff, 3'b101},
      '{32'hffffffff, 32'h60, 32'h0,        48'h81c001000000, 3'd6, 2'd0, 32'h00000000, 3'b101}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] le(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   task automatic put_byte(input logic [7:0] b);
      fetch_valid = 1'b1;
      fetch_byte  = b;
      while (!fetch_ready) @(negedge clk);
      @(negedge clk);
      fetch_valid = 1'b0;
   endtask

   task automatic wait_done();
      int t = 0;
      while (!done && t < 200) begin
         @(negedge clk);
         t++;
      end
      if (!done) check("R11 timeout waiting for done", 32'd0, 32'd1);
      @(negedge clk);
   endtask

   task automatic run_code(input logic [47:0] code, input int n);
      for (int i = 0; i < n; i++) put_byte(code[47-8*i -: 8]);
      wait_done();
   endtask

   task automatic mov_reg(input int r, input logic [31:0] v);
      run_code({8'hb8 | {5'd0, 3'(r)}, le(v), 8'h00}, 5);
   endtask

   task automatic read_reg(input int r, output logic [31:0] v);
      dbg_sel = 3'(r);
      #1;
      v = dbg_data;
   endtask

   function automatic logic [31:0] mem_word(input int a);
      return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
   endfunction

   task automatic set_word(input int a, input logic [31:0] v);
      for (int i = 0; i < 4; i++) mem[a+i] = v[8*i +: 8];
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      rst = 1'b1;
      fetch_valid = 1'b0;
      fetch_byte = 8'h00;
      dbg_sel = 3'd0;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      @(negedge clk);
      do_reset();

      // R13: reset state
      for (int r = 0; r < 8; r++) begin
         read_reg(r, v);
         check("R13 register cleared", v, 32'h0);
      end
      check("R13 flags cleared", {29'd0, flag_sign, flag_zero, flag_ovf}, 32'h0);
      check("R13 not halted, fetching", {30'd0, halted, fetch_ready}, 32'h1);

      // vector table
      for (int k = 0; k < NV; k++) begin
         int    d0;
         logic  is_cmp;
         string vt;
         string ft;
         mov_reg(0, VEC[k].eax0);
         mov_reg(3, VEC[k].ebx0);
         set_word(32'h60, VEC[k].mem0);
         d0 = done_n;
         run_code(VEC[k].code, int'(VEC[k].n));
         is_cmp = (VEC[k].code[47:40] == 8'h3d) ||
                  (VEC[k].code[47:40] == 8'h81 && VEC[k].code[37:35] == 3'd7);
         vt = (VEC[k].n == 3'd5) ? "R4 short form" :
              (VEC[k].chk == 2'd2) ? "R10 memory operand" : "R3 register operand";
         ft = is_cmp ? "R5 compare flags" : "R6 flags preserved";
         case (VEC[k].chk)
            2'd0:    read_reg(0, v);
            2'd1:    read_reg(3, v);
            default: v = mem_word(32'h60);
         endcase
         check($sformatf("%s vec %0d", vt, k), v, VEC[k].expv);
         check($sformatf("%s vec %0d", ft, k),
               {29'd0, flag_sign, flag_zero, flag_ovf}, {29'd0, VEC[k].expf});
         check($sformatf("R11 one done per instr vec %0d", k), done_n - d0, 32'd1);
      end

      // R7: register index ordering
      for (int r = 0; r < 8; r++) mov_reg(r, 32'h10203040 + r * 32'h01010101);
      for (int r = 0; r < 8; r++) begin
         read_reg(r, v);
         check($sformatf("R7 load reg %0d", r), v, 32'h10203040 + r * 32'h01010101);
      end

      // R2: byte order of the immediate
      run_code(48'hb80a0b0c0d00, 5);
      read_reg(0, v);
      check("R2 little-endian immediate", v, 32'h0d0c0b0a);

      // R8: copy immediate to register and to memory
      run_code(48'hc7c144332211, 6);
      read_reg(1, v);
      check("R8 copy to register", v, 32'h11223344);
      mov_reg(3, 32'h60);
      set_word(32'h60, 32'hffffffff);
      log_n = 0;
      run_code(48'hc70378563412, 6);
      check("R8 copy to memory", mem_word(32'h60), 32'h12345678);
      check("R8 no memory read, four writes", log_n, 32'd4);
      check("R8 first transfer is a write", {23'd0, mlog[0]}, 32'h160);

      // R10: read-modify-write ordering
      set_word(32'h60, 32'h5);
      log_n = 0;
      run_code(48'h810301000000, 6);
      check("R10 rmw result", mem_word(32'h60), 32'h6);
      check("R10 transfer count", log_n, 32'd8);
      for (int i = 0; i < 4; i++) begin
         check($sformatf("R10 read %0d", i), {23'd0, mlog[i]}, 32'h060 + i);
         check($sformatf("R10 write %0d", i), {23'd0, mlog[4+i]}, 32'h160 + i);
      end

      // R9: push
      mov_reg(4, 32'h14);
      log_n = 0;
      run_code(48'h68af00000000, 5);
      read_reg(4, v);
      check("R9 stack pointer lowered", v, 32'h10);
      check("R9 pushed word", mem_word(32'h10), 32'h000000af);
      check("R9 first write address", {23'd0, mlog[0]}, 32'h110);

      // R1 / R12: illegal sub-operation
      do_reset();
      mov_reg(3, 32'h77);
      put_byte(8'h81);
      put_byte(8'hd3);
      check("R1 sub-op 2 raises err", {31'd0, err}, 32'd1);
      check("R12 halted after err", {31'd0, halted}, 32'd1);
      check("R12 fetch stopped", {31'd0, fetch_ready}, 32'd0);
      read_reg(3, v);
      check("R1 register untouched", v, 32'h77);
      @(negedge clk);
      check("R12 err is a pulse", {30'd0, err, halted}, 32'd1);

      // R13: reset leaves halt
      do_reset();
      read_reg(3, v);
      check("R13 reset clears halt and registers", {halted, v[30:0]}, 32'h0);

      // R12: unknown opcode
      put_byte(8'h90);
      check("R12 unknown opcode halts", {30'd0, err, halted}, 32'd3);

      // R3: unsupported addressing modes
      do_reset();
      put_byte(8'h81);
      put_byte(8'h43);
      check("R3 mode 1 rejected", {30'd0, err, halted}, 32'd3);
      do_reset();
      put_byte(8'hc7);
      put_byte(8'h04);
      check("R3 mode 0 rm 4 rejected", {30'd0, err, halted}, 32'd3);
      do_reset();
      put_byte(8'h81);
      put_byte(8'h1b);
      check("R1 sub-op 3 raises err", {30'd0, err, halted}, 32'd3);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule